// File: doc/BRIEF.md
# Macro Program Upload Capture

This block sits on the register-write stream that a command front end produces. It watches writes that target the low front-end method space and gathers the words of a macro program into a local buffer. It does not execute macros and does not hold the macro store. Each complete program leaves the block as a burst of commit beats that a separate store can write away.

An entry-select write names the program slot and empties the buffer. Each code-word write adds one 32-bit word. The code word that arrives with a remaining-parameter count of zero closes the program. No explicit length is ever sent. While no entry is latched, the entry register holds the all-ones sentinel. The same decoder also handles the bind method, which records the engine identifier assigned to a subchannel in a small table that can be read back.

The controller has three states:
- `ST_IDLE`: no entry latched.
- `ST_COLLECT`: entry latched, words being gathered.
- `ST_DRAIN`: buffered words being emitted.

The transitions are:
- select (`ST_IDLE` to `ST_COLLECT` on an entry-select write).
- reselect (`ST_COLLECT` to `ST_COLLECT` on a further entry-select write).
- close (`ST_COLLECT` to `ST_DRAIN` on a code word with remaining count zero).
- done (`ST_DRAIN` to `ST_IDLE` after the last beat).

Top module: `macro_upload_capture`

## Requirements
- R1: After reset, `cur_entry` is 32'hFFFFFFFF, `cm_valid`, `bind_valid`, `err_overflow` and `err_orphan` are 0, `wr_ready` is 1, and `q_engine` reads 0 for every subchannel.
- R2: A write is accepted only on a clock edge where `wr_valid` and `wr_ready` are both 1. An accepted write to method 0x47 sets `cur_entry` to `wr_data` and discards every word gathered before it, including during a pending upload.
- R3: An accepted write to method 0x46 with a nonzero `wr_remain` while an entry is latched stores `wr_data` as the next word and produces no commit beat.
- R4: An accepted write to method 0x46 with `wr_remain` equal to zero while an entry is latched stores the word and then closes the program. Starting on the next cycle, the block asserts `cm_valid` for exactly N consecutive cycles, where N is the number of stored words. Across those cycles `cm_index` runs from 0 to N-1 and `cm_word` carries the words in arrival order. `cm_last` is asserted only on the final beat, and `wr_ready` is 0 during every beat.
- R5: During every beat, `cm_key` equals the latched entry times two plus 0xE00, taken modulo 2^32.
- R6: After the final beat, `cur_entry` returns to 32'hFFFFFFFF.
- R7: The buffer holds 64 words. A code word that arrives when it is full is dropped and sets `err_overflow`, which then stays 1 until reset. If the closing word is dropped, the program still commits with the first 64 words.
- R8: An accepted write to method 0x46 while `cur_entry` holds the sentinel is ignored. It sets `err_orphan`, which stays 1 until reset, produces no beat, and leaves `cur_entry` unchanged.
- R9: Method 0x45, any other method below 0x100 not named here, and every method at or above 0x100 change neither the gathered program, `cur_entry`, the error flags nor the bind table.
- R10: An accepted write to method 0 pulses `bind_valid` for one cycle on the next cycle, with `bind_subch` set to `wr_subch` and `bind_engine` set to the low 16 bits of `wr_data`. From then on, `q_engine` returns that identifier when `q_subch` selects that subchannel.
- R11: A write presented while `wr_ready` is 0 has no effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write presented |
| wr_ready | output | 1 | Block can accept a write this cycle |
| wr_method | input | 12 | Method address of the write |
| wr_subch | input | 3 | Subchannel of the write |
| wr_data | input | 32 | Write data |
| wr_remain | input | 13 | Parameters still to follow in this command |
| cm_valid | output | 1 | Commit beat valid |
| cm_key | output | 32 | Macro method address of the committed program |
| cm_index | output | 6 | Word position within the program |
| cm_word | output | 32 | Program word |
| cm_last | output | 1 | Final beat of the program |
| cur_entry | output | 32 | Latched entry, or the sentinel |
| err_overflow | output | 1 | Sticky buffer overflow flag |
| err_orphan | output | 1 | Sticky flag for a code word with no entry latched |
| bind_valid | output | 1 | Bind recorded last cycle |
| bind_subch | output | 3 | Subchannel of the recorded bind |
| bind_engine | output | 16 | Engine identifier of the recorded bind |
| q_subch | input | 3 | Subchannel to look up |
| q_engine | output | 16 | Engine identifier bound to `q_subch` |

## Verification
The assertions assume that the write source honours `wr_ready`, so a write offered during a drain is simply not taken. They also assume that a reset precedes any use. The directed scenarios drive every write on the falling edge and hold it for one full cycle. One scenario deliberately presents an entry-select write while the drain is running, to show that it is refused. The remaining counts in the stimulus always count down to zero the way a real command would. The only exceptions are the reselect scenario and the overflow scenario, which exercise the buffer-discard and buffer-full paths.

// File: rtl/mu_pkg.sv
package mu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_DRAIN
    } mu_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_BIND,
        OP_ENTRY,
        OP_CODE
    } mu_op_e;

    localparam logic [7:0]  MTH_BIND     = 8'h00;
    localparam logic [7:0]  MTH_CODE     = 8'h46;
    localparam logic [7:0]  MTH_ENTRY    = 8'h47;
    localparam int unsigned FE_LIMIT     = 32'h100;
    localparam logic [31:0] MACRO_BASE   = 32'h0000_0E00;
    localparam logic [31:0] ENTRY_NONE   = 32'hFFFF_FFFF;

endpackage

// File: rtl/mu_decode.sv
module mu_decode
    import mu_pkg::*;
#(
    parameter int MTH_W = 12
) (
    input  logic             acc,
    input  logic [MTH_W-1:0] method,
    output mu_op_e           op
);

    logic in_fe;

    always_comb begin
        in_fe = (32'(method) < FE_LIMIT);
        op    = OP_NONE;
        if (acc && in_fe) begin
            unique case (method[7:0])
                MTH_BIND:  op = OP_BIND;
                MTH_ENTRY: op = OP_ENTRY;
                MTH_CODE:  op = OP_CODE;
                default:   op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/mu_fsm.sv
module mu_fsm
    import mu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  mu_op_e    op,
    input  logic      rem_zero,
    input  logic      buf_full,
    input  logic      rd_last,
    output mu_state_e state,
    output logic      ready,
    output logic      lat_entry,
    output logic      append,
    output logic      set_ovf,
    output logic      set_orph,
    output logic      draining,
    output logic      done
);

    mu_state_e st_q, st_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Transitions: select, reselect, close, done
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (op == OP_ENTRY) st_d = ST_COLLECT;
            end
            ST_COLLECT: begin
                if (op == OP_CODE && rem_zero) st_d = ST_DRAIN;
                else                           st_d = ST_COLLECT;
            end
            ST_DRAIN: begin
                if (rd_last) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Control outputs
    always_comb begin
        ready     = 1'b1;
        lat_entry = 1'b0;
        append    = 1'b0;
        set_ovf   = 1'b0;
        set_orph  = 1'b0;
        draining  = 1'b0;
        done      = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                lat_entry = (op == OP_ENTRY);
                set_orph  = (op == OP_CODE);
            end
            ST_COLLECT: begin
                lat_entry = (op == OP_ENTRY);
                append    = (op == OP_CODE) && !buf_full;
                set_ovf   = (op == OP_CODE) && buf_full;
            end
            ST_DRAIN: begin
                ready    = 1'b0;
                draining = 1'b1;
                done     = rd_last;
            end
            default: ready = 1'b1;
        endcase
    end

    assign state = st_q;

endmodule

// File: rtl/mu_codebuf.sv
module mu_codebuf #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              append,
    input  logic [DATA_W-1:0] din,
    input  logic              draining,
    output logic              full,
    output logic              rd_last,
    output logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] dout
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  rd_q;

    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign rd_last = draining && (CNT_W'(rd_q) == cnt_q - CNT_W'(1));
    assign rd_idx  = rd_q;
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (append) mem[cnt_q[IDX_W-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rd_q  <= '0;
        end else begin
            if (clear || rd_last)  cnt_q <= '0;
            else if (append)       cnt_q <= cnt_q + CNT_W'(1);
            if (rd_last)           rd_q  <= '0;
            else if (draining)     rd_q  <= rd_q + IDX_W'(1);
        end
    end

endmodule

// File: rtl/mu_bindtab.sv
module mu_bindtab #(
    parameter int SC_W  = 3,
    parameter int ENG_W = 16,
    localparam int N_SC = 1 << SC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SC_W-1:0]  wr_sc,
    input  logic [ENG_W-1:0] wr_eng,
    output logic             ev_valid,
    output logic [SC_W-1:0]  ev_sc,
    output logic [ENG_W-1:0] ev_eng,
    input  logic [SC_W-1:0]  q_sc,
    output logic [ENG_W-1:0] q_eng
);

    logic [ENG_W-1:0] tab_q [N_SC];

    for (genvar g = 0; g < N_SC; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                             tab_q[g] <= '0;
            else if (wr && wr_sc == SC_W'(g))       tab_q[g] <= wr_eng;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_valid <= 1'b0;
            ev_sc    <= '0;
            ev_eng   <= '0;
        end else begin
            ev_valid <= wr;
            if (wr) begin
                ev_sc  <= wr_sc;
                ev_eng <= wr_eng;
            end
        end
    end

    assign q_eng = tab_q[q_sc];

endmodule

// File: rtl/macro_upload_capture.sv
module macro_upload_capture
    import mu_pkg::*;
#(
    parameter int MTH_W  = 12,
    parameter int SC_W   = 3,
    parameter int REM_W  = 13,
    parameter int DEPTH  = 64,
    parameter int ENG_W  = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [MTH_W-1:0] wr_method,
    input  logic [SC_W-1:0]  wr_subch,
    input  logic [31:0]      wr_data,
    input  logic [REM_W-1:0] wr_remain,
    output logic             cm_valid,
    output logic [31:0]      cm_key,
    output logic [IDX_W-1:0] cm_index,
    output logic [31:0]      cm_word,
    output logic             cm_last,
    output logic [31:0]      cur_entry,
    output logic             err_overflow,
    output logic             err_orphan,
    output logic             bind_valid,
    output logic [SC_W-1:0]  bind_subch,
    output logic [ENG_W-1:0] bind_engine,
    input  logic [SC_W-1:0]  q_subch,
    output logic [ENG_W-1:0] q_engine
);

    mu_op_e    op;
    mu_state_e state;
    logic      acc, ready, lat_entry, append, set_ovf, set_orph, draining, done;
    logic      buf_full, rd_last;
    logic [31:0] entry_q;
    logic      ovf_q, orph_q;

    assign acc = wr_valid && ready;

    mu_decode #(.MTH_W(MTH_W)) u_dec (
        .acc    (acc),
        .method (wr_method),
        .op     (op)
    );

    mu_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .rem_zero  (wr_remain == '0),
        .buf_full  (buf_full),
        .rd_last   (rd_last),
        .state     (state),
        .ready     (ready),
        .lat_entry (lat_entry),
        .append    (append),
        .set_ovf   (set_ovf),
        .set_orph  (set_orph),
        .draining  (draining),
        .done      (done)
    );

    mu_codebuf #(.DEPTH(DEPTH), .DATA_W(32)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (lat_entry),
        .append   (append),
        .din      (wr_data),
        .draining (draining),
        .full     (buf_full),
        .rd_last  (rd_last),
        .rd_idx   (cm_index),
        .dout     (cm_word)
    );

    mu_bindtab #(.SC_W(SC_W), .ENG_W(ENG_W)) u_bind (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (op == OP_BIND),
        .wr_sc    (wr_subch),
        .wr_eng   (wr_data[ENG_W-1:0]),
        .ev_valid (bind_valid),
        .ev_sc    (bind_subch),
        .ev_eng   (bind_engine),
        .q_sc     (q_subch),
        .q_eng    (q_engine)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_q <= ENTRY_NONE;
            ovf_q   <= 1'b0;
            orph_q  <= 1'b0;
        end else begin
            if (lat_entry)  entry_q <= wr_data;
            else if (done)  entry_q <= ENTRY_NONE;
            if (set_ovf)    ovf_q   <= 1'b1;
            if (set_orph)   orph_q  <= 1'b1;
        end
    end

    assign wr_ready     = ready;
    assign cm_valid     = (state == ST_DRAIN);
    assign cm_key       = {entry_q[30:0], 1'b0} + MACRO_BASE;
    assign cm_last      = rd_last;
    assign cur_entry    = entry_q;
    assign err_overflow = ovf_q;
    assign err_orphan   = orph_q;

endmodule

// File: rtl/macro_upload_capture_chk.sv
module macro_upload_capture_chk #(
    parameter int IDX_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_ready,
    input logic             cm_valid,
    input logic             cm_last,
    input logic [IDX_W-1:0] cm_index,
    input logic [31:0]      cm_key,
    input logic [31:0]      cur_entry,
    input logic             err_overflow,
    input logic             err_orphan,
    input logic             bind_valid
);

    // R4
    drain_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cm_valid |-> !wr_ready);

    // R4
    burst_starts_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cm_valid) |-> cm_index == '0);

    // R4
    burst_contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !cm_last) |=> (cm_valid && cm_index == $past(cm_index) + IDX_W'(1)));

    // R4
    burst_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && cm_last) |=> !cm_valid);

    // R5
    key_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && !cm_last) |=> $stable(cm_key));

    // R6
    entry_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_valid && cm_last) |=> cur_entry == 32'hFFFF_FFFF);

    // R7
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |=> err_overflow);

    // R8
    orphan_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_orphan |=> err_orphan);

    // R10
    bind_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bind_valid && cm_valid) |-> $past(wr_ready));

endmodule

bind macro_upload_capture macro_upload_capture_chk #(.IDX_W(IDX_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_ready     (wr_ready),
    .cm_valid     (cm_valid),
    .cm_last      (cm_last),
    .cm_index     (cm_index),
    .cm_key       (cm_key),
    .cur_entry    (cur_entry),
    .err_overflow (err_overflow),
    .err_orphan   (err_orphan),
    .bind_valid   (bind_valid)
);

// File: tb/macro_upload_capture_tb_top.sv
module macro_upload_capture_tb_top;

    localparam logic [31:0] NONE = 32'hFFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic        wr_ready;
    logic [11:0] wr_method = '0;
    logic [2:0]  wr_subch = '0;
    logic [31:0] wr_data = '0;
    logic [12:0] wr_remain = '0;
    logic        cm_valid;
    logic [31:0] cm_key;
    logic [5:0]  cm_index;
    logic [31:0] cm_word;
    logic        cm_last;
    logic [31:0] cur_entry;
    logic        err_overflow, err_orphan;
    logic        bind_valid;
    logic [2:0]  bind_subch;
    logic [15:0] bind_engine;
    logic [2:0]  q_subch = '0;
    logic [15:0] q_engine;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] exp_w [64];

    always #10 clk = ~clk;

    macro_upload_capture dut_i (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
        .wr_method(wr_method), .wr_subch(wr_subch), .wr_data(wr_data),
        .wr_remain(wr_remain), .cm_valid(cm_valid), .cm_key(cm_key),
        .cm_index(cm_index), .cm_word(cm_word), .cm_last(cm_last),
        .cur_entry(cur_entry), .err_overflow(err_overflow), .err_orphan(err_orphan),
        .bind_valid(bind_valid), .bind_subch(bind_subch), .bind_engine(bind_engine),
        .q_subch(q_subch), .q_engine(q_engine)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one write at a falling edge; returns at the next falling edge
    task automatic put(input logic [11:0] m, input logic [2:0] sc, input logic [31:0] d,
                       input logic [12:0] rem);
        wr_valid  = 1'b1;
        wr_method = m;
        wr_subch  = sc;
        wr_data   = d;
        wr_remain = rem;
        @(negedge clk);
        wr_valid  = 1'b0;
    endtask

    task automatic drain_check(input logic [31:0] key, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            chk(cm_valid, {tag, " R4 valid"}, 32'(cm_valid), 1);
            chk(cm_index == 6'(i), {tag, " R4 index"}, 32'(cm_index), i);
            chk(cm_word == exp_w[i], {tag, " R4 word"}, cm_word, exp_w[i]);
            chk(cm_last == (i == n - 1), {tag, " R4 last"}, 32'(cm_last), 32'(i == n - 1));
            chk(!wr_ready, {tag, " R4 ready"}, 32'(wr_ready), 0);
            chk(cm_key == key, {tag, " R5 key"}, cm_key, key);
            @(negedge clk);
        end
        chk(!cm_valid, {tag, " R4 end"}, 32'(cm_valid), 0);
        chk(cur_entry == NONE, {tag, " R6 entry"}, cur_entry, NONE);
    endtask

    task automatic t_reset();
        chk(cur_entry == NONE, "R1 entry", cur_entry, NONE);
        chk(!cm_valid && !bind_valid, "R1 valids", {cm_valid, bind_valid}, 0);
        chk(!err_overflow && !err_orphan, "R1 errors", {err_overflow, err_orphan}, 0);
        chk(wr_ready, "R1 ready", 32'(wr_ready), 1);
        for (int s = 0; s < 8; s++) begin
            q_subch = 3'(s);
            #1;
            chk(q_engine == 0, "R1 table", 32'(q_engine), 0);
        end
    endtask

    task automatic t_basic();
        put(12'h047, 0, 32'd3, 0);
        chk(cur_entry == 32'd3, "R2 latch", cur_entry, 3);
        exp_w[0] = 32'hA0A0_0001; exp_w[1] = 32'hB0B0_0002; exp_w[2] = 32'hC0C0_0003;
        put(12'h046, 0, exp_w[0], 2);
        chk(!cm_valid, "R3 no beat", 32'(cm_valid), 0);
        put(12'h046, 0, exp_w[1], 1);
        chk(!cm_valid, "R3 no beat", 32'(cm_valid), 0);
        put(12'h046, 0, exp_w[2], 0);
        drain_check(32'h0000_0E06, 3, "basic");
    endtask

    task automatic t_reselect();
        put(12'h047, 0, 32'd1, 0);
        put(12'h046, 0, 32'h1111_1111, 5);
        put(12'h046, 0, 32'h2222_2222, 4);
        put(12'h047, 0, 32'd2, 0);
        chk(cur_entry == 32'd2, "R2 relatch", cur_entry, 2);
        exp_w[0] = 32'h3333_3333;
        put(12'h046, 0, exp_w[0], 0);
        drain_check(32'h0000_0E04, 1, "reselect R2");
    endtask

    task automatic t_keywrap();
        put(12'h047, 0, 32'h8000_0010, 0);
        exp_w[0] = 32'hDEAD_BEEF; exp_w[1] = 32'h0BAD_F00D;
        put(12'h046, 0, exp_w[0], 1);
        put(12'h046, 0, exp_w[1], 0);
        drain_check(32'h0000_0E20, 2, "wrap R5");
    endtask

    task automatic t_ignored();
        put(12'h047, 0, 32'd7, 0);
        put(12'h045, 0, 32'h5555_5555, 0);
        put(12'h010, 0, 32'h6666_6666, 0);
        put(12'h146, 0, 32'h7777_7777, 0);
        put(12'h147, 0, 32'h0000_0009, 0);
        put(12'h100, 2, 32'h0000_ABCD, 0);
        chk(cur_entry == 32'd7, "R9 entry kept", cur_entry, 7);
        chk(!cm_valid, "R9 no beat", 32'(cm_valid), 0);
        q_subch = 3'd2;
        #1;
        chk(q_engine == 0, "R9 table kept", 32'(q_engine), 0);
        exp_w[0] = 32'h8888_8888;
        put(12'h046, 0, exp_w[0], 0);
        drain_check(32'h0000_0E0E, 1, "ignored R9");
        chk(!err_overflow && !err_orphan, "R9 no error", {err_overflow, err_orphan}, 0);
    endtask

    task automatic t_bind();
        put(12'h000, 3'd5, 32'h1234_B197, 0);
        chk(bind_valid, "R10 pulse", 32'(bind_valid), 1);
        chk(bind_subch == 3'd5, "R10 subch", 32'(bind_subch), 5);
        chk(bind_engine == 16'hB197, "R10 engine", 32'(bind_engine), 32'hB197);
        q_subch = 3'd5;
        #1;
        chk(q_engine == 16'hB197, "R10 lookup", 32'(q_engine), 32'hB197);
        q_subch = 3'd4;
        #1;
        chk(q_engine == 0, "R10 other slot", 32'(q_engine), 0);
        @(negedge clk);
        chk(!bind_valid, "R10 single pulse", 32'(bind_valid), 0);
    endtask

    task automatic t_blocked();
        put(12'h047, 0, 32'd4, 0);
        exp_w[0] = 32'h0000_00AA; exp_w[1] = 32'h0000_00BB;
        put(12'h046, 0, exp_w[0], 1);
        put(12'h046, 0, exp_w[1], 0);
        chk(cm_valid && !wr_ready, "R11 draining", {cm_valid, wr_ready}, 2);
        wr_valid = 1'b1; wr_method = 12'h047; wr_data = 32'd9; wr_remain = 0;
        @(negedge clk);
        wr_method = 12'h000; wr_subch = 3'd6; wr_data = 32'h0000_00EE;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(cur_entry == NONE, "R11 entry", cur_entry, NONE);
        q_subch = 3'd6;
        #1;
        chk(q_engine == 0, "R11 table", 32'(q_engine), 0);
        chk(!cm_valid, "R11 end", 32'(cm_valid), 0);
    endtask

    task automatic t_orphan();
        put(12'h046, 0, 32'h4444_4444, 0);
        chk(err_orphan, "R8 flag", 32'(err_orphan), 1);
        chk(cur_entry == NONE, "R8 entry", cur_entry, NONE);
        chk(!cm_valid, "R8 no beat", 32'(cm_valid), 0);
        @(negedge clk);
        chk(err_orphan, "R8 sticky", 32'(err_orphan), 1);
    endtask

    task automatic t_overflow();
        put(12'h047, 0, 32'd9, 0);
        for (int i = 0; i < 66; i++) begin
            if (i < 64) exp_w[i] = 32'h100 + 32'(i);
            put(12'h046, 0, 32'h100 + 32'(i), 13'(65 - i));
            if (i == 63) chk(!err_overflow, "R7 not yet", 32'(err_overflow), 0);
        end
        chk(err_overflow, "R7 flag", 32'(err_overflow), 1);
        drain_check(32'h0000_0E12, 64, "overflow R7");
        chk(err_overflow, "R7 sticky", 32'(err_overflow), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_reselect();
        t_keywrap();
        t_ignored();
        t_bind();
        t_blocked();
        t_orphan();
        t_overflow();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule